// File: doc/BRIEF.md
# Sampled Signed Sample Port Peripheral

This peripheral sits on a processor's extension register bus and moves signed 8-bit samples between software and a pair of converter ports: one input sample bus and one output sample bus. A control register selects how the data register behaves. With the control register at zero, the block works as a plain pass-through. A data read returns the present input sample, and a data write drives the output sample at once.

With the control register at a non-zero value N, the block streams samples. A timer derived from the system clock fires once every N × 10 µs. On each firing it captures one input sample into a receive queue and moves one sample from a transmit queue to the output port. Software drains the receive queue through data reads and fills the transmit queue through data writes. The usable depth of both queues shrinks as the period grows, so each queue spans roughly a 20 ms window. A control read in this mode reports how many received samples are waiting.

The bus side uses single-cycle strobes: software may issue one access in any cycle. Software sees back-pressure only as a queue limit. A write to a full transmit queue and a capture into a full receive queue are both dropped. A dropped capture raises a sticky overflow pin. The converter side is a level interface with no handshake, because the converters run at the fixed sample rate and cannot stall.

Top module: `sampled_io_periph`

## Requirements
- R1: After reset the block is in pass-through mode, `dac_sample` is 0, `rx_overflow` is 0, and a control read returns 1.
- R2: In pass-through mode, a data read (address 275) returns `adc_sample` sign-extended to the bus width. A data write sets `dac_sample` to write bits [7:0] at the clock edge of the write.
- R3: A control read (address 274) returns 1 in pass-through mode and the receive queue occupancy in streaming mode. Control reads never change queue state.
- R4: Writing N (bits [7:0], 1..255) to the control register selects streaming mode. It restarts the timer so that sample events fall on the clock edges N·10·CLK_PER_US, 2N·10·CLK_PER_US, and so on, counted after the write edge.
- R5: In streaming mode, data reads return received samples sign-extended, oldest first, and each such read removes one sample.
- R6: A data read in streaming mode with an empty receive queue returns 0 and leaves the occupancy unchanged.
- R7: Queue capacity is max(8, floor(2048/N)). A capture into a full receive queue discards the new sample and sets `rx_overflow`, which stays set until the next control write clears it.
- R8: On each sample event, the oldest transmit sample, if any, drives `dac_sample`. With the transmit queue empty, `dac_sample` keeps its value.
- R9: Any control write empties both queues.
- R10: In streaming mode, a data write to a full transmit queue is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address (274 control, 275 data) |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid from the edge that takes the read |
| adc_sample | input | 8 | Signed input sample from the converter |
| dac_sample | output | 8 | Signed output sample to the converter |
| rx_overflow | output | 1 | Sticky flag for a dropped capture |

## Verification
The assertions assume `bus_wr` and `bus_rd` are never high in the same cycle. They also assume `adc_sample` is steady across each sample edge, and that reset is held long enough to reach the first clock edge. The bench drives every strobe and input on the falling clock edge and holds it for one full cycle. It issues at most one access per cycle. It also changes the input sample only on the falling edge just before a scheduled sample edge. Because of this, every timing-relative property sees clean, single-access cycles.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int CTRL_ADDR = 274;
  localparam int DATA_ADDR = 275;
  localparam int MIN_CAP   = 8;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/sio_tick_gen.sv
module sio_tick_gen #(
  parameter int CLK_PER_US  = 4,
  parameter int US_PER_UNIT = 10,
  parameter int PER_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             enable,
  input  logic [PER_W-1:0] period,
  output logic             sample_tick
);
  localparam int UW = (CLK_PER_US  > 1) ? $clog2(CLK_PER_US)  : 1;
  localparam int DW = (US_PER_UNIT > 1) ? $clog2(US_PER_UNIT) : 1;

  logic [UW-1:0]    us_cnt;
  logic [DW-1:0]    unit_cnt;
  logic [PER_W-1:0] per_cnt;
  logic us_tick, unit_tick;

  assign us_tick     = enable && (us_cnt == UW'(CLK_PER_US - 1));
  assign unit_tick   = us_tick && (unit_cnt == DW'(US_PER_UNIT - 1));
  assign sample_tick = unit_tick && (per_cnt == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart || !enable) begin
      us_cnt   <= '0;
      unit_cnt <= '0;
      per_cnt  <= '0;
    end else begin
      us_cnt <= us_tick ? '0 : us_cnt + UW'(1);
      if (us_tick) unit_cnt <= unit_tick ? '0 : unit_cnt + DW'(1);
      if (unit_tick) per_cnt <= sample_tick ? '0 : per_cnt + PER_W'(1);
    end
  end
endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DEPTH = 2048,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (count >= cap);
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/sampled_io_periph.sv
module sampled_io_periph
  import sio_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 16,
  parameter int MEM_DEPTH  = 2048,
  parameter int CLK_PER_US = 4,
  parameter int US_PER_UNIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        adc_sample,
  output logic [7:0]        dac_sample,
  output logic              rx_overflow
);
  localparam int CNT_W = $clog2(MEM_DEPTH) + 1;
  localparam int EXT_W = DATA_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] mode_q;
  logic [CNT_W-1:0]    cap_q, cap_div, cap_new;
  logic sel_ctrl, sel_data, ctrl_wr, data_wr, data_rd, direct, sample_tick;
  logic [SAMPLE_W-1:0] rx_dout, tx_dout;
  logic [CNT_W-1:0]    rx_count, tx_count;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic unused_hi;

  assign unused_hi = ^{bus_wdata[DATA_W-1:SAMPLE_W], tx_count, tx_full};

  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign sel_data = (bus_addr == ADDR_W'(DATA_ADDR));
  assign ctrl_wr  = bus_wr && sel_ctrl;
  assign data_wr  = bus_wr && sel_data;
  assign data_rd  = bus_rd && sel_data;
  assign direct   = (mode_q == '0);

  // capacity for a newly written period: floor(depth/N), at least MIN_CAP
  always_comb begin
    cap_div = CNT_W'(MEM_DEPTH);
    if (bus_wdata[SAMPLE_W-1:0] != '0)
      cap_div = CNT_W'(MEM_DEPTH) / {{(CNT_W-SAMPLE_W){1'b0}}, bus_wdata[SAMPLE_W-1:0]};
    cap_new = (cap_div < CNT_W'(MIN_CAP)) ? CNT_W'(MIN_CAP) : cap_div;
  end

  sio_tick_gen #(
    .CLK_PER_US (CLK_PER_US),
    .US_PER_UNIT(US_PER_UNIT),
    .PER_W      (SAMPLE_W)
  ) u_tick (
    .clk        (clk),
    .rst        (rst),
    .restart    (ctrl_wr),
    .enable     (!direct),
    .period     (mode_q),
    .sample_tick(sample_tick)
  );

  sio_fifo #(.DEPTH(MEM_DEPTH), .W(SAMPLE_W)) u_rx (
    .clk  (clk),
    .rst  (rst),
    .flush(ctrl_wr),
    .cap  (cap_q),
    .push (sample_tick),
    .din  (adc_sample),
    .pop  (data_rd && !direct),
    .dout (rx_dout),
    .count(rx_count),
    .full (rx_full),
    .empty(rx_empty)
  );

  sio_fifo #(.DEPTH(MEM_DEPTH), .W(SAMPLE_W)) u_tx (
    .clk  (clk),
    .rst  (rst),
    .flush(ctrl_wr),
    .cap  (cap_q),
    .push (data_wr && !direct),
    .din  (bus_wdata[SAMPLE_W-1:0]),
    .pop  (sample_tick),
    .dout (tx_dout),
    .count(tx_count),
    .full (tx_full),
    .empty(tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= '0;
      cap_q       <= CNT_W'(MEM_DEPTH);
      rx_overflow <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q      <= bus_wdata[SAMPLE_W-1:0];
      cap_q       <= cap_new;
      rx_overflow <= 1'b0;
    end else if (sample_tick && rx_full) begin
      rx_overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         dac_sample <= '0;
    else if (data_wr && direct)      dac_sample <= bus_wdata[SAMPLE_W-1:0];
    else if (sample_tick && !tx_empty) dac_sample <= tx_dout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_ctrl)
        bus_rdata <= direct ? DATA_W'(1) : DATA_W'(rx_count);
      else if (sel_data && direct)
        bus_rdata <= {{EXT_W{adc_sample[SAMPLE_W-1]}}, adc_sample};
      else if (sel_data && !rx_empty)
        bus_rdata <= {{EXT_W{rx_dout[SAMPLE_W-1]}}, rx_dout};
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/sio_checker.sv
module sio_checker #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        wr_lo,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [7:0]        dac_sample,
  input logic              rx_overflow,
  input logic [7:0]        mode_q,
  input logic              sample_tick,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  cap_q
);
  logic at_ctrl, at_data, pass;
  assign at_ctrl = (bus_addr == ADDR_W'(sio_pkg::CTRL_ADDR));
  assign at_data = (bus_addr == ADDR_W'(sio_pkg::DATA_ADDR));
  assign pass    = (mode_q == 8'd0);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dac_sample == 8'd0 && !rx_overflow && mode_q == 8'd0));

  a_r2_direct_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_data && pass) |=> dac_sample == $past(wr_lo));

  a_r3_direct_status: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_ctrl && pass) |=> bus_rdata == DATA_W'(1));

  a_r6_empty_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_data && !pass && rx_count == '0) |=> bus_rdata == '0);

  a_r7_within_cap: assert property (@(posedge clk) disable iff (rst)
    rx_count <= cap_q);

  a_r7_sticky_flag: assert property (@(posedge clk) disable iff (rst)
    (rx_overflow && !(bus_wr && at_ctrl)) |=> rx_overflow);

  a_r8_output_hold: assert property (@(posedge clk) disable iff (rst)
    (!sample_tick && !(bus_wr && at_data && pass)) |=> $stable(dac_sample));
endmodule

bind sampled_io_periph sio_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W ($clog2(MEM_DEPTH) + 1)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .wr_lo      (bus_wdata[7:0]),
  .bus_rdata  (bus_rdata),
  .dac_sample (dac_sample),
  .rx_overflow(rx_overflow),
  .mode_q     (mode_q),
  .sample_tick(sample_tick),
  .rx_count   (rx_count),
  .cap_q      (cap_q)
);

// File: tb/sampled_io_periph_tb.sv
module sampled_io_periph_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int CTRL       = 274;
  localparam int DATA       = 275;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  adc_sample = '0;
  logic [7:0]  dac_sample;
  logic        rx_overflow;

  int nchk = 0, nfail = 0, cyc = 0;
  int rxq[$];
  int txq[$];
  int exp_dac = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sampled_io_periph #(.CLK_PER_US(CPU)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_sample(adc_sample),
    .dac_sample(dac_sample), .rx_overflow(rx_overflow)
  );

  function automatic int sx8(logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic int cap_of(int n);
    int c = 2048 / n;
    return (c < 8) ? 8 : c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; the access is taken at the next rising edge
  task automatic bus_write(int a, int d);
    bus_addr = 9'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    bus_addr = 9'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'($signed(bus_rdata));
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // returns the rising edge index of the control write
  task automatic set_mode(int n, output int c0);
    c0 = cyc + 1;
    bus_write(CTRL, n);
    rxq.delete(); txq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int rd, c0, p, v, op;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R3: state after reset
    chk("R1 dac after reset", sx8(dac_sample), 0);
    chk("R1 overflow after reset", int'(rx_overflow), 0);
    bus_read(CTRL, rd); chk("R1 R3 ctrl read in pass-through", rd, 1);

    // R2: pass-through with random samples, extremes included
    for (int i = 0; i < 20; i++) begin
      v = (i == 0) ? 8'h80 : (i == 1) ? 8'h7f : int'($urandom_range(0, 255));
      adc_sample = 8'(v);
      bus_read(DATA, rd); chk("R2 direct read", rd, sx8(8'(v)));
      v = $urandom_range(0, 255);
      bus_write(DATA, v | (int'($urandom_range(0, 255)) << 8));
      exp_dac = sx8(8'(v));
      chk("R2 direct write", sx8(dac_sample), exp_dac);
    end

    // Streaming with N=1
    set_mode(1, c0);
    p = 10 * CPU;
    bus_read(DATA, rd); chk("R6 empty read value", rd, 0);
    bus_read(CTRL, rd); chk("R6 occupancy after empty read", rd, 0);
    chk("R8 dac held on mode change", sx8(dac_sample), exp_dac);

    // R4: first sample event lands exactly P edges after the write
    wait_until(c0 + p - 1);
    v = $urandom_range(0, 255); adc_sample = 8'(v); rxq.push_back(sx8(8'(v)));
    bus_read(CTRL, rd); chk("R4 no sample before period", rd, 0);
    bus_read(CTRL, rd); chk("R4 sample at period edge", rd, 1);

    for (int k = 2; k <= 40; k++) begin
      wait_until(c0 + k * p - 1);
      v = $urandom_range(0, 255); adc_sample = 8'(v); rxq.push_back(sx8(8'(v)));
      if (txq.size() > 0) exp_dac = txq.pop_front();
      @(negedge clk);
      chk("R8 dac after sample event", sx8(dac_sample), exp_dac);
      op = $urandom_range(0, 2);
      if (op == 0) begin
        bus_read(DATA, rd);
        chk("R5 receive order", rd, (rxq.size() > 0) ? rxq.pop_front() : 0);
      end else if (op == 1) begin
        v = $urandom_range(0, 255);
        bus_write(DATA, v);
        txq.push_back(sx8(8'(v)));
      end else begin
        bus_read(CTRL, rd); chk("R3 occupancy read", rd, rxq.size());
      end
    end

    // R9 / R4: rewrite flushes and restarts the timer
    chk("R9 queue nonempty before flush", int'(rxq.size() > 0), 1);
    wait_until(c0 + 40 * p + 5);
    v = $urandom_range(1, 127); bus_write(DATA, v);   // lands in tx queue
    set_mode(1, c0);
    bus_read(CTRL, rd); chk("R9 receive queue flushed", rd, 0);
    bus_read(DATA, rd); chk("R9 R6 flushed data read", rd, 0);
    wait_until(c0 + p - 1);
    adc_sample = 8'h11;
    bus_read(CTRL, rd); chk("R4 restart no early event", rd, 0);
    bus_read(CTRL, rd); chk("R4 restart event", rd, 1);
    chk("R9 transmit queue flushed", sx8(dac_sample), exp_dac);

    // N=255: capacity 8, overflow and transmit drops
    set_mode(255, c0);
    p = 255 * 10 * CPU;
    for (int i = 0; i < 10; i++) begin
      v = $urandom_range(0, 255);
      bus_write(DATA, v);
      if (txq.size() < cap_of(255)) txq.push_back(sx8(8'(v)));
    end
    for (int k = 1; k <= 9; k++) begin
      wait_until(c0 + k * p - 1);
      v = $urandom_range(0, 255); adc_sample = 8'(v);
      if (rxq.size() < cap_of(255)) rxq.push_back(sx8(8'(v)));
      if (txq.size() > 0) exp_dac = txq.pop_front();
      @(negedge clk);
      chk("R8 R10 dac sequence", sx8(dac_sample), exp_dac);
      chk("R7 overflow flag", int'(rx_overflow), (k == 9) ? 1 : 0);
    end
    bus_read(CTRL, rd); chk("R7 capacity occupancy", rd, 8);
    for (int i = 0; i < 8; i++) begin
      bus_read(DATA, rd); chk("R5 R7 kept samples", rd, rxq.pop_front());
    end
    chk("R7 flag sticky after drain", int'(rx_overflow), 1);

    set_mode(0, c0);
    chk("R7 flag cleared by control write", int'(rx_overflow), 0);
    bus_read(CTRL, rd); chk("R3 back to pass-through", rd, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule